// File: doc/BRIEF.md
# Timer Tick Prescale and Divide Stage

This block turns one peripheral clock into five count-enable tick streams, one for each channel of a timer bank. Two free-running 8-bit prescalers each serve a fixed group of channels: channels 0 and 1 share the low prescaler, and channels 2, 3 and 4 share the high prescaler. Each channel then passes its group's prescaler pulse through its own power-of-two divider. The output is a registered tick that lasts one clock cycle.

Software sets the stage through a small 32-bit register port with a write strobe and a combinational read. The word at offset 0x00 holds the two prescale values. The word at offset 0x04 holds a 4-bit divider code for each channel. A build parameter sets the divider code offset. With offset 1 (the narrow-counter variant), code 0 divides by 2. With offset 0 (the wide-counter variant), code 0 divides by 1. The counters that consume the ticks sit outside this block.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset both configuration words read as zero. This gives a prescale of 1 and the smallest divisor: a tick period of 2 cycles when the code offset is 1, and 1 cycle when the offset is 0.
- R2: Offset 0x00 holds the low-group prescale field in bits [7:0] and the high-group field in bits [15:8]. Bits [31:16] read as zero.
- R3: Offset 0x04 holds the 4-bit divider code of channel c in bits [4c+3:4c], for c = 0..4. Bits [31:20] read as zero.
- R4: A write to any offset other than 0x00 or 0x04, or any cycle with the write strobe low, leaves both words unchanged.
- R5: A prescale field value N divides the clock by N+1.
- R6: Channels 0 and 1 follow the field in bits [7:0]. Channels 2, 3 and 4 follow the field in bits [15:8].
- R7: A divider code k selects a divisor of 2^(k+B), where B is the code offset parameter (default 1).
- R8: When k+B is above 4, the divisor is 16.
- R9: In steady state the tick period of a channel is (N+1) times its divisor, in clock cycles.
- R10: When the period is 2 or more, each tick is high for exactly one clock cycle.
- R11: A register write never restarts a prescaler. A new prescale value takes effect only when the running count reaches the old limit and wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_o | output | 5 | Count-enable tick per channel |

## Verification
The tick period is measured with the two prescale fields set to different values. This separates the low channel group from the high channel group, and would expose a channel wired to the wrong prescaler. Divider codes are swept across small values, the last in-range value and out-of-range values, on both code-offset variants. Together these tell a correct log2 offset from an off-by-one and a clamp from a wraparound. A slow prescale value is then replaced mid-count. The gap to the next tick shows whether the new value waited for the old wrap or restarted the count.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

  localparam logic [7:0] OFS_PRE = 8'h00;
  localparam logic [7:0] OFS_SEL = 8'h04;

  // log2 of divisor for a selector code, saturated
  function automatic int unsigned sel_shift(int unsigned code, int unsigned base,
                                            int unsigned max_shift);
    int unsigned s;
    s = code + base;
    return (s > max_shift) ? max_shift : s;
  endfunction

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import tmr_tick_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic [2*PRE_W-1:0]      pre_cfg_o,
  output logic [NUM_CH*SEL_W-1:0] sel_cfg_o
);

  localparam int unsigned PRE_BITS = 2 * PRE_W;
  localparam int unsigned SEL_BITS = NUM_CH * SEL_W;

  logic [PRE_BITS-1:0] pre_q;
  logic [SEL_BITS-1:0] sel_q;
  logic                hit_pre, hit_sel;

  assign hit_pre = (addr_i == ADDR_W'(OFS_PRE));
  assign hit_sel = (addr_i == ADDR_W'(OFS_SEL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sel_q <= '0;
    end else if (we_i) begin
      if (hit_pre) pre_q <= wdata_i[PRE_BITS-1:0];
      if (hit_sel) sel_q <= wdata_i[SEL_BITS-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_pre)      rdata_o[PRE_BITS-1:0] = pre_q;
    else if (hit_sel) rdata_o[SEL_BITS-1:0] = sel_q;
  end

  assign pre_cfg_o = pre_q;
  assign sel_cfg_o = sel_q;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] lim_i,
  output logic             pulse_o
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim_q;   // limit in force until the next wrap
  logic             wrap;

  assign wrap = (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      lim_q <= lim_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pulse_o = wrap;

endmodule

// File: rtl/tmr_chan_div.sv
module tmr_chan_div
  import tmr_tick_pkg::*;
#(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned DIV_BASE  = 1,
  parameter int unsigned MAX_SHIFT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int unsigned CNT_W = MAX_SHIFT;

  logic [CNT_W-1:0] div_cnt_q;
  logic [CNT_W-1:0] mask;
  int unsigned      shift;
  logic             fire;

  always_comb begin
    shift = sel_shift(32'(sel_i), DIV_BASE, MAX_SHIFT);
    mask  = CNT_W'((32'd1 << shift) - 32'd1);
  end

  assign fire = pre_tick_i & (&(div_cnt_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      tick_o    <= 1'b0;
    end else begin
      if (pre_tick_i) div_cnt_q <= div_cnt_q + 1'b1;
      tick_o <= fire;
    end
  end

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned NUM_CH    = 5,
  parameter int unsigned GRP0_CH   = 2,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DIV_BASE  = 1,
  parameter int unsigned MAX_SHIFT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] tick_o
);

  localparam int unsigned NUM_GRP = 2;

  logic [NUM_GRP*PRE_W-1:0] pre_cfg;
  logic [NUM_CH*SEL_W-1:0]  sel_cfg;
  logic [NUM_GRP-1:0]       pre_tick;

  tmr_cfg_regs #(
    .NUM_CH(NUM_CH), .PRE_W(PRE_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pre_cfg_o (pre_cfg),
    .sel_cfg_o (sel_cfg)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lim_i   (pre_cfg[g*PRE_W +: PRE_W]),
      .pulse_o (pre_tick[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < GRP0_CH) ? 0 : 1;
    tmr_chan_div #(
      .SEL_W(SEL_W), .DIV_BASE(DIV_BASE), .MAX_SHIFT(MAX_SHIFT)
    ) u_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pre_tick_i (pre_tick[GRP]),
      .sel_i      (sel_cfg[c*SEL_W +: SEL_W]),
      .tick_o     (tick_o[c])
    );
  end

endmodule

// File: rtl/tmr_tick_chk.sv
module tmr_tick_chk
  import tmr_tick_pkg::*;
#(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DIV_BASE = 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [NUM_CH-1:0]       tick_o,
  input logic [1:0]              pre_tick,
  input logic [2*PRE_W-1:0]      pre_cfg,
  input logic [NUM_CH*SEL_W-1:0] sel_cfg
);

  AST_TICK_LOW_GRP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[0] |-> $past(pre_tick[0]));                                  // R6

  AST_TICK_HIGH_GRP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[NUM_CH-1] |-> $past(pre_tick[1]));                           // R6

  AST_ONE_CYCLE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DIV_BASE > 0 && tick_o[0]) |=> !tick_o[0]);                        // R10

  AST_PRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(OFS_PRE)) |=> $stable(pre_cfg));        // R4

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(OFS_SEL)) |=> $stable(sel_cfg));        // R4

endmodule

bind tmr_tick_gen tmr_tick_chk #(
  .NUM_CH(NUM_CH), .PRE_W(PRE_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DIV_BASE(DIV_BASE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .tick_o   (tick_o),
  .pre_tick (pre_tick),
  .pre_cfg  (pre_cfg),
  .sel_cfg  (sel_cfg)
);

// File: tb/sim_tmr_tick_gen.sv
module sim_tmr_tick_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [4:0]  tick0, tick1;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_tick_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata0), .tick_o(tick0)
  );

  tmr_tick_gen #(.DIV_BASE(0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata1), .tick_o(tick1)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 8'hFC; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata0;
  endtask

  function automatic logic tk(input int which, input int ch);
    return (which == 0) ? tick0[ch] : tick1[ch];
  endfunction

  task automatic wait_tick(input int which, input int ch, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tk(which, ch) && n < 4000);
  endtask

  // sync on two ticks, then measure one full gap
  task automatic period(input int which, input int ch, output int n);
    int dummy;
    wait_tick(which, ch, dummy);
    wait_tick(which, ch, dummy);
    wait_tick(which, ch, n);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int p;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h00, d); check("R1 pre word", int'(d), 0);
    rd(8'h04, d); check("R1 sel word", int'(d), 0);
    period(0, 0, p); check("R1 base1 default period", p, 2);
    period(1, 0, p); check("R7 base0 code0 period", p, 1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h00, 32'hDEAD_0402);
    rd(8'h00, d); check("R2 pre readback", int'(d), 32'h0000_0402);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R3 sel readback", int'(d), 32'h000F_FFFF);
    wr(8'h04, 32'h0000_0000);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    @(negedge clk); we = 1'b0; addr = 8'h00; wdata = 32'h0000_7777;
    @(negedge clk); addr = 8'h04;
    @(negedge clk);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R4 pre unchanged", int'(d), 32'h0000_0402);
    rd(8'h04, d); check("R4 sel unchanged", int'(d), 0);
  endtask

  task automatic t_group();
    int p;
    period(0, 0, p); check("R5 ch0 prescale 3 x2", p, 6);
    period(0, 1, p); check("R6 ch1 low group", p, 6);
    period(0, 2, p); check("R6 ch2 high group", p, 10);
    period(0, 4, p); check("R6 ch4 high group", p, 10);
  endtask

  task automatic t_divsel();
    int p;
    wr(8'h04, 32'h0000_1200);
    period(0, 2, p); check("R7 ch2 code2 base1", p, 40);
    period(0, 3, p); check("R7 ch3 code1 base1", p, 20);
    period(1, 2, p); check("R7 ch2 code2 base0", p, 20);
  endtask

  task automatic t_clamp();
    int p;
    wr(8'h04, 32'h0003_0009);
    period(0, 0, p); check("R8 ch0 code9 clamp", p, 48);
    period(0, 4, p); check("R9 ch4 5x16", p, 80);
    period(1, 0, p); check("R8 base0 code9 clamp", p, 48);
    wr(8'h04, 32'h000F_0009);
    period(0, 4, p); check("R8 ch4 code15 clamp", p, 80);
  endtask

  task automatic t_width();
    int p;
    wait_tick(0, 0, p);
    @(negedge clk);
    check("R10 tick one cycle", int'(tick0[0]), 0);
  endtask

  task automatic t_wrap();
    int p, n;
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0000_0063);
    period(0, 0, p); check("R9 100x2 period", p, 200);
    wait_tick(0, 0, p);
    n = 0;
    repeat (10) begin @(negedge clk); n++; end
    we = 1'b1; addr = 8'h00; wdata = 32'h0;
    @(negedge clk); n++;
    we = 1'b0; addr = 8'hFC;
    while (!tick0[0] && n < 4000) begin @(negedge clk); n++; end
    check("R11 waits old wrap", n, 101);
    wait_tick(0, 0, p); check("R11 new value after wrap", p, 2);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_ignore();
    t_group();
    t_divsel();
    t_clamp();
    t_width();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule